// File: doc/BRIEF.md
# Oversampled serial receiver with multidrop address filter

This block recovers asynchronous serial frames from a single receive line, using a 16x oversampling tick from an external rate generator. Each recovered byte goes into a 16-entry receive queue together with a framing-error flag and an address-frame flag. The host reads the queue head combinationally and removes it with a pop strobe.

The host selects one of four fill thresholds for a level-sensitive interrupt request. It can also shrink the queue to a single holding register. In the 9-bit multidrop mode, a ninth data bit marks a frame as an address. The block then either compares addresses with its own station address and only admits data that follow a matching address, or stores every frame and tags addresses so software can decide.

Top module: `rx_addr_uart`

## Requirements
- R1: With the queue enabled, up to 16 entries are held and read out in arrival order; a frame completing while 16 entries are held is not stored.
- R2: The interrupt request is high exactly while the stored count is at or above the threshold chosen by `cfg_trig_sel` (0 → 1, 1 → 4, 2 → 8, 3 → 14 entries).
- R3: With `cfg_fifo_en` low, at most one entry is held; a second frame arriving before it is popped is dropped, the first is kept, and the interrupt request follows the single entry.
- R4: Any change of `cfg_fifo_en` empties the store.
- R5: A low level on the line that has ended before the middle of the start bit (8th oversample tick) produces no frame.
- R6: In 8-bit mode a frame is one low start bit, eight data bits least significant first, one stop bit; the data appear unchanged on `rd_data`.
- R7: A stop bit sampled low stores the frame with `rd_frame_err` high for that entry; a high stop bit stores it with the flag low.
- R8: Dropping a frame for lack of space sets `overrun`, which stays high until a `status_rd` pulse clears it.
- R9: In 9-bit mode with automatic matching, address frames (ninth bit 1) are never stored; data frames (ninth bit 0) are stored only after an address equal to `cfg_station`, and are refused again after a different address; before any address, data are refused.
- R10: In 9-bit mode without automatic matching, every frame is stored and `rd_addr_flag` equals its ninth bit.
- R11: `data_ready` is high exactly while at least one entry is held; a pop on an empty store has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rxd | input | 1 | Serial receive line, idle high |
| baud_tick | input | 1 | One-cycle strobe at 16 times the bit rate |
| cfg_fifo_en | input | 1 | 1: 16-entry queue, 0: single holding register |
| cfg_trig_sel | input | 2 | Interrupt threshold select |
| cfg_nine_bit | input | 1 | Enable 9-bit multidrop frames |
| cfg_auto_addr | input | 1 | Hardware address matching in 9-bit mode |
| cfg_station | input | 8 | Own station address |
| rd_pop | input | 1 | Remove the head entry |
| status_rd | input | 1 | Status read strobe, clears overrun |
| rd_data | output | 8 | Head entry data |
| rd_frame_err | output | 1 | Head entry had a low stop bit |
| rd_addr_flag | output | 1 | Head entry is an address frame |
| data_ready | output | 1 | At least one entry held |
| trig_irq | output | 1 | Fill at or above threshold |
| overrun | output | 1 | Sticky lost-frame flag |

## Verification
The bench builds the block with its default depth of 16 and 16x oversampling and strobes the tick every other clock, so one bit lasts 32 clocks. With a queue this small, every threshold setting can be swept over every fill count from 1 to 17, which reaches the full and overflow boundary for each threshold. The same sweep reads all entries back in order. Directed frames then cover a rejected start glitch, a bad stop bit, the single-register mode, the flush on a mode change, and address sequences that take the match state through refused, admitted and refused again.

// File: rtl/rx_addr_pkg.sv
// Package: shared entry type and threshold decode for the receiver.
// Assumes 8-bit data; the ninth bit only travels as a flag.
package rx_addr_pkg;
    localparam int DATA_W = 8;

    typedef struct packed {
        logic              is_addr;
        logic              ferr;
        logic [DATA_W-1:0] data;
    } rx_entry_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP
    } rx_state_t;

    // Map the 2-bit threshold select onto a stored-entry count.
    function automatic int unsigned trig_level(input logic [1:0] sel);
        case (sel)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 14;
        endcase
    endfunction
endpackage

// File: rtl/rx_deser.sv
// Module: oversampled frame deserializer.
// Detects a falling edge on the synchronized line, confirms it in the middle
// of the start bit, then samples each data bit and the stop bit once per OSR
// ticks. Emits a one-cycle frame strobe with data (ninth bit at index DW) and
// a framing-error flag. Assumes the line is already synchronized.
module rx_deser
    import rx_addr_pkg::*;
#(
    parameter int OSR = 16,
    parameter int DW  = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rxd_s,
    input  logic        tick,
    input  logic        nine_bit,
    output logic        frm_valid,
    output logic [DW:0] frm_data,
    output logic        frm_ferr
);
    localparam int CW = $clog2(OSR);
    localparam int BW = $clog2(DW + 1);
    localparam logic [CW-1:0] CNT_MID  = CW'(OSR / 2 - 2);
    localparam logic [CW-1:0] CNT_LAST = CW'(OSR - 1);

    rx_state_t     st;
    logic [CW-1:0] cnt;
    logic [BW-1:0] bit_idx;
    logic [DW:0]   shreg;
    logic [BW-1:0] last_idx;

    // Index of the final data bit for the selected frame length.
    always_comb last_idx = nine_bit ? BW'(DW) : BW'(DW - 1);

    // Frame sequencer: start validation, data sampling, stop check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            cnt       <= '0;
            bit_idx   <= '0;
            shreg     <= '0;
            frm_valid <= 1'b0;
            frm_data  <= '0;
            frm_ferr  <= 1'b0;
        end else begin
            frm_valid <= 1'b0;
            if (tick) begin
                case (st)
                    ST_IDLE: begin
                        if (!rxd_s) begin
                            st  <= ST_START;
                            cnt <= '0;
                        end
                    end
                    ST_START: begin
                        if (cnt == CNT_MID) begin
                            if (!rxd_s) begin
                                st      <= ST_DATA;
                                cnt     <= '0;
                                bit_idx <= '0;
                                shreg   <= '0;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (cnt == CNT_LAST) begin
                            cnt            <= '0;
                            shreg[bit_idx] <= rxd_s;
                            if (bit_idx == last_idx) st <= ST_STOP;
                            else                     bit_idx <= bit_idx + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: begin
                        if (cnt == CNT_LAST) begin
                            frm_valid <= 1'b1;
                            frm_data  <= shreg;
                            frm_ferr  <= !rxd_s;
                            st        <= ST_IDLE;
                            cnt       <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/rx_addr_gate.sv
// Module: multidrop address filter.
// Decides per completed frame whether it enters the store. In automatic mode
// it keeps a "selected" state that a matching address sets and a different
// address clears; address frames themselves are not stored.
module rx_addr_gate
    import rx_addr_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frm_valid,
    input  logic [DW:0]   frm_data,
    input  logic          frm_ferr,
    input  logic          nine_bit,
    input  logic          auto_addr,
    input  logic [DW-1:0] station,
    output logic          push,
    output rx_entry_t     push_entry
);
    logic selected;
    logic is_addr;

    // Ninth bit counts only when 9-bit frames are in use.
    always_comb is_addr = nine_bit && frm_data[DW];

    // Store decision and entry formation for the current frame.
    always_comb begin
        push_entry.data    = frm_data[DW-1:0];
        push_entry.ferr    = frm_ferr;
        push_entry.is_addr = is_addr;
        push               = 1'b0;
        if (frm_valid) begin
            if (!nine_bit || !auto_addr) push = 1'b1;
            else if (!is_addr)           push = selected;
        end
    end

    // Track whether the last address frame named this station.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            selected <= 1'b0;
        end else if (frm_valid && is_addr && auto_addr) begin
            selected <= (frm_data[DW-1:0] == station);
        end
    end
endmodule

// File: rtl/rx_store.sv
// Module: receive queue with threshold request and overrun flag.
// Capacity is DEPTH entries, or one entry in holding-register mode. A change
// of the mode input empties it. The head entry is shown combinationally.
module rx_store
    import rx_addr_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       fifo_en,
    input  logic [1:0]                 trig_sel,
    input  logic                       push,
    input  rx_entry_t                  push_entry,
    input  logic                       pop,
    input  logic                       status_rd,
    output rx_entry_t                  head,
    output logic [$clog2(DEPTH+1)-1:0] fill,
    output logic                       flush,
    output logic                       data_ready,
    output logic                       trig_irq,
    output logic                       overrun
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

    rx_entry_t     mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          en_q;
    logic [CW-1:0] cap, thr;
    logic          full, do_push, do_pop;

    // Capacity, threshold and handshake qualification.
    always_comb begin
        flush      = (en_q != fifo_en);
        cap        = fifo_en ? CW'(DEPTH) : CW'(1);
        thr        = fifo_en ? CW'(trig_level(trig_sel)) : CW'(1);
        full       = (fill >= cap);
        do_push    = push && !full && !flush;
        do_pop     = pop && (fill != '0) && !flush;
        data_ready = (fill != '0);
        trig_irq   = (fill >= thr);
        head       = mem[rd_ptr];
    end

    // Entry storage; written only on an accepted push.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_entry;
    end

    // Pointers, fill count and mode tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
            en_q   <= 1'b1;
        end else begin
            en_q <= fifo_en;
            if (flush) begin
                wr_ptr <= '0;
                rd_ptr <= '0;
                fill   <= '0;
            end else begin
                if (do_push) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
                if (do_pop)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
                if (do_push && !do_pop)      fill <= fill + 1'b1;
                else if (do_pop && !do_push) fill <= fill - 1'b1;
            end
        end
    end

    // Sticky lost-frame flag; a new loss wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                      overrun <= 1'b0;
        else if (push && full && !flush) overrun <= 1'b1;
        else if (status_rd)              overrun <= 1'b0;
    end
endmodule

// File: rtl/rx_addr_uart.sv
// Module: top of the receive path.
// Synchronizes the line, deserializes frames, filters them by address and
// queues them. Assumes baud_tick is a single-cycle strobe at OSR times the
// bit rate and that configuration changes only between frames.
module rx_addr_uart
    import rx_addr_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int OSR   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd,
    input  logic              baud_tick,
    input  logic              cfg_fifo_en,
    input  logic [1:0]        cfg_trig_sel,
    input  logic              cfg_nine_bit,
    input  logic              cfg_auto_addr,
    input  logic [DATA_W-1:0] cfg_station,
    input  logic              rd_pop,
    input  logic              status_rd,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_frame_err,
    output logic              rd_addr_flag,
    output logic              data_ready,
    output logic              trig_irq,
    output logic              overrun
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [1:0]        sync_q;
    logic              frm_valid;
    logic [DATA_W:0]   frm_data;
    logic              frm_ferr;
    logic              push;
    rx_entry_t         push_entry;
    rx_entry_t         head;
    logic [CW-1:0]     fill_cnt;
    logic              flush;

    // Two-stage synchronizer; resets to the idle-high line level.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rxd};
    end

    rx_deser #(.OSR(OSR), .DW(DATA_W)) deser_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rxd_s     (sync_q[1]),
        .tick      (baud_tick),
        .nine_bit  (cfg_nine_bit),
        .frm_valid (frm_valid),
        .frm_data  (frm_data),
        .frm_ferr  (frm_ferr)
    );

    rx_addr_gate #(.DW(DATA_W)) gate_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .frm_valid  (frm_valid),
        .frm_data   (frm_data),
        .frm_ferr   (frm_ferr),
        .nine_bit   (cfg_nine_bit),
        .auto_addr  (cfg_auto_addr),
        .station    (cfg_station),
        .push       (push),
        .push_entry (push_entry)
    );

    rx_store #(.DEPTH(DEPTH)) store_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_en    (cfg_fifo_en),
        .trig_sel   (cfg_trig_sel),
        .push       (push),
        .push_entry (push_entry),
        .pop        (rd_pop),
        .status_rd  (status_rd),
        .head       (head),
        .fill       (fill_cnt),
        .flush      (flush),
        .data_ready (data_ready),
        .trig_irq   (trig_irq),
        .overrun    (overrun)
    );

    // Present the head entry fields on the read port.
    always_comb begin
        rd_data      = head.data;
        rd_frame_err = head.ferr;
        rd_addr_flag = head.is_addr;
    end
endmodule

// File: rtl/rx_addr_uart_chk.sv
// Module: property checker attached to the receiver top by bind.
module rx_addr_uart_chk #(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] fill,
    input logic          flush,
    input logic          fifo_en,
    input logic          frm_valid,
    input logic          frm_ninth,
    input logic          nine_bit,
    input logic          auto_addr,
    input logic          rd_pop,
    input logic          status_rd,
    input logic          overrun,
    input logic          trig_irq,
    input logic          data_ready
);
    p_fill_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CW'(DEPTH));

    p_irq_needs_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        trig_irq |-> data_ready);

    p_single_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && !flush) |=> fill <= 1);

    p_flush_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> fill == '0);

    p_addr_not_stored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && frm_ninth && nine_bit && auto_addr && !rd_pop && !flush)
        |=> $stable(fill));

    p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !status_rd) |=> overrun);

    p_pop_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == '0 && !frm_valid) |=> fill == '0);
endmodule

bind rx_addr_uart rx_addr_uart_chk #(.DEPTH(DEPTH), .CW($clog2(DEPTH + 1))) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .fill       (fill_cnt),
    .flush      (flush),
    .fifo_en    (cfg_fifo_en),
    .frm_valid  (frm_valid),
    .frm_ninth  (frm_data[8]),
    .nine_bit   (cfg_nine_bit),
    .auto_addr  (cfg_auto_addr),
    .rd_pop     (rd_pop),
    .status_rd  (status_rd),
    .overrun    (overrun),
    .trig_irq   (trig_irq),
    .data_ready (data_ready)
);

// File: tb/rx_addr_uart_tb_top.sv
// Bench: sweeps thresholds and fill counts, then directed address cases.
module rx_addr_uart_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int BIT_CLKS   = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic       baud_tick = 1'b0;
    logic       cfg_fifo_en = 1'b1;
    logic [1:0] cfg_trig_sel = 2'd0;
    logic       cfg_nine_bit = 1'b0;
    logic       cfg_auto_addr = 1'b0;
    logic [7:0] cfg_station = 8'h5A;
    logic       rd_pop = 1'b0;
    logic       status_rd = 1'b0;
    logic [7:0] rd_data;
    logic       rd_frame_err, rd_addr_flag, data_ready, trig_irq, overrun;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) baud_tick <= ~baud_tick;

    rx_addr_uart dut_i (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .baud_tick(baud_tick),
        .cfg_fifo_en(cfg_fifo_en), .cfg_trig_sel(cfg_trig_sel),
        .cfg_nine_bit(cfg_nine_bit), .cfg_auto_addr(cfg_auto_addr),
        .cfg_station(cfg_station), .rd_pop(rd_pop), .status_rd(status_rd),
        .rd_data(rd_data), .rd_frame_err(rd_frame_err),
        .rd_addr_flag(rd_addr_flag), .data_ready(data_ready),
        .trig_irq(trig_irq), .overrun(overrun)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Serialize one frame; bad_stop holds the stop bit low for its first 10 ticks.
    task automatic send(input logic [8:0] v, input bit nb, input bit bad_stop);
        @(negedge clk) rxd = 1'b0;
        repeat (BIT_CLKS) @(negedge clk);
        for (int i = 0; i < (nb ? 9 : 8); i++) begin
            rxd = v[i];
            repeat (BIT_CLKS) @(negedge clk);
        end
        rxd = !bad_stop;
        repeat (20) @(negedge clk);
        rxd = 1'b1;
        repeat (BIT_CLKS + 12) @(negedge clk);
    endtask

    task automatic pop_chk(input string tag, input int d, input int ad, input int fe);
        chk({tag, " ready"}, data_ready, 1);
        chk({tag, " data"}, rd_data, d);
        chk({tag, " addr flag"}, rd_addr_flag, ad);
        chk({tag, " ferr"}, rd_frame_err, fe);
        rd_pop = 1'b1;
        @(negedge clk) rd_pop = 1'b0;
        @(negedge clk);
    endtask

    task automatic toggle_mode();
        @(negedge clk) cfg_fifo_en = ~cfg_fifo_en;
        @(negedge clk) cfg_fifo_en = ~cfg_fifo_en;
        @(negedge clk);
    endtask

    task automatic clr_status();
        @(negedge clk) status_rd = 1'b1;
        @(negedge clk) status_rd = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 reset ready", data_ready, 0);
        chk("R2 reset irq", trig_irq, 0);
        chk("R8 reset overrun", overrun, 0);

        // Threshold sweep with full fill, overflow and ordered read-back.
        for (int s = 0; s < 4; s++) begin
            int thr;
            thr = (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
            cfg_trig_sel = 2'(s);
            toggle_mode();
            for (int n = 1; n <= 16; n++) begin
                send(9'((n * 29 + s * 7) & 8'hFF), 1'b0, 1'b0);
                chk("R2 irq level", trig_irq, (n >= thr) ? 1 : 0);
                chk("R11 ready", data_ready, 1);
            end
            chk("R8 no overrun yet", overrun, 0);
            send(9'h0A5, 1'b0, 1'b0);
            chk("R8 overrun set", overrun, 1);
            @(negedge clk);
            chk("R8 overrun holds", overrun, 1);
            clr_status();
            chk("R8 overrun cleared", overrun, 0);
            for (int n = 1; n <= 16; n++)
                pop_chk("R1 R6 order", (n * 29 + s * 7) & 8'hFF, 0, 0);
            chk("R1 17th dropped", data_ready, 0);
            rd_pop = 1'b1;
            @(negedge clk) rd_pop = 1'b0;
            chk("R11 pop on empty", data_ready, 0);
        end

        // R5: short low pulse is not a start bit.
        @(negedge clk) rxd = 1'b0;
        repeat (6) @(negedge clk);
        rxd = 1'b1;
        repeat (3 * BIT_CLKS) @(negedge clk);
        chk("R5 glitch ignored", data_ready, 0);

        // R7: framing error flagged per entry.
        send(9'h0C3, 1'b0, 1'b1);
        send(9'h03C, 1'b0, 1'b0);
        pop_chk("R7 bad stop", 8'hC3, 0, 1);
        pop_chk("R7 good stop", 8'h3C, 0, 0);

        // R3: holding-register mode.
        cfg_trig_sel = 2'd3;
        @(negedge clk) cfg_fifo_en = 1'b0;
        @(negedge clk);
        send(9'h011, 1'b0, 1'b0);
        chk("R3 irq single", trig_irq, 1);
        send(9'h022, 1'b0, 1'b0);
        chk("R3 overrun", overrun, 1);
        pop_chk("R3 first kept", 8'h11, 0, 0);
        chk("R3 second dropped", data_ready, 0);
        clr_status();

        // R4: mode change empties the store.
        @(negedge clk) cfg_fifo_en = 1'b1;
        @(negedge clk);
        send(9'h033, 1'b0, 1'b0);
        send(9'h044, 1'b0, 1'b0);
        chk("R4 filled", data_ready, 1);
        @(negedge clk) cfg_fifo_en = 1'b0;
        @(negedge clk) @(negedge clk);
        chk("R4 flushed", data_ready, 0);
        @(negedge clk) cfg_fifo_en = 1'b1;
        @(negedge clk) @(negedge clk);
        chk("R4 flushed back", data_ready, 0);

        // R9: automatic address matching.
        cfg_nine_bit = 1'b1;
        cfg_auto_addr = 1'b1;
        send(9'h011, 1'b1, 1'b0);
        chk("R9 data before address", data_ready, 0);
        send(9'h133, 1'b1, 1'b0);
        send(9'h022, 1'b1, 1'b0);
        chk("R9 foreign address", data_ready, 0);
        send(9'h15A, 1'b1, 1'b0);
        chk("R9 own address not stored", data_ready, 0);
        send(9'h044, 1'b1, 1'b0);
        send(9'h055, 1'b1, 1'b0);
        send(9'h160, 1'b1, 1'b0);
        send(9'h066, 1'b1, 1'b0);
        pop_chk("R9 admitted", 8'h44, 0, 0);
        pop_chk("R9 admitted", 8'h55, 0, 0);
        chk("R9 refused after mismatch", data_ready, 0);

        // R10: software address handling.
        cfg_auto_addr = 1'b0;
        send(9'h177, 1'b1, 1'b0);
        send(9'h012, 1'b1, 1'b0);
        pop_chk("R10 address", 8'h77, 1, 0);
        pop_chk("R10 data", 8'h12, 0, 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule